// File: doc/BRIEF.md
# Programmed-I/O FIFO with Command Capture

This block is the byte FIFO register seen by a host driving a SCSI controller by programmed I/O. In normal operation, a host write pushes one byte into a small data buffer and a host read pops the oldest byte. Once a select-with-attention-and-stop command has been issued, the same write strobe is redirected into a separate 32-byte command buffer. Host writes keep going there until the command bytes are released to the consumer.

The block also keeps a small register set: a status byte, an interrupt cause, a sequence step and a FIFO flags value, plus an interrupt line. Two commands update this set: the select-with-attention-and-stop command, and the initiator-command-complete command. The second one preloads a two-byte status/message answer for the host to read. All outputs are registered and change on the clock edge at which the strobe is sampled. Only one of `sel_stop`, `resp_load`, `cmd_release`, `host_wr` and `host_rd` is expected in a cycle. If several are raised together, the first in that list wins. `irq_ack` and `phase_load` may accompany any of them.

Top module: `pio_fifo_port`

## Requirements
- R1: After a synchronous active-low reset, the following outputs are all zero: `fifo_level`, `irq`, `status_reg`, `intr_cause`, `seq_step`, `fifo_flags`, `cmd_pending`, `cmd_len` and `host_rd_data`.
- R2: With no command pending, a host write stores the byte and raises `fifo_level` by one. Host reads return the bytes in write order.
- R3: A host write that arrives while `fifo_level` equals DEPTH-1 is discarded and leaves `fifo_level` unchanged.
- R4: A host read with a non-zero level lowers `fifo_level` by one and sets `irq`. A host read at level zero changes nothing: `host_rd_data` keeps its value and `irq` is not set.
- R5: While `status_reg[2:0]` is 3'b000 (data-out phase), a host read still lowers the level but returns 0x00. It does not advance the read position, so the skipped byte is returned by the next read taken in another phase.
- R6: When a read brings the level to zero, both buffer positions return to zero. The next written byte is then the next one read.
- R7: While `cmd_pending` is 1, host writes go to the command buffer and increment `cmd_len`, and `fifo_level` does not change. Once `cmd_len` reaches 32, further writes are discarded. `cmd_byte` shows the entry selected by `cmd_idx`.
- R8: `sel_stop` sets `cmd_pending`, clears `cmd_len` and empties the data buffer. It also loads `status_reg`=0x12 (terminal count bit 4 plus command phase 3'b010), `intr_cause`=0x18 (bus service bit 4 plus function complete bit 3), `seq_step`=4, `fifo_flags`=0, and sets `irq`.
- R9: `cmd_release` clears `cmd_pending`. Later writes go to the data buffer again, and `cmd_len` is kept.
- R10: `resp_load` fills the data buffer with `resp_status` followed by 0x00, so `fifo_level`=2. It sets `fifo_flags`=2, `intr_cause`=0x08, ORs 3'b111 (message-in phase) into `status_reg[2:0]`, and sets `irq`.
- R11: `irq_ack` clears `irq` and `intr_cause`. An event that sets `irq` in the same cycle wins.
- R12: `phase_load` writes `phase_val` into `status_reg[2:0]` and leaves the upper status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe to the FIFO register |
| host_wr_data | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host read strobe from the FIFO register |
| host_rd_data | output | 8 | Byte returned by the most recent successful read |
| sel_stop | input | 1 | Select-with-attention-and-stop command |
| resp_load | input | 1 | Initiator-command-complete command |
| resp_status | input | 8 | Status byte placed first in the response |
| cmd_release | input | 1 | Command bytes taken by the consumer; ends capture |
| irq_ack | input | 1 | Interrupt acknowledge |
| phase_load | input | 1 | Load a new bus phase into the status byte |
| phase_val | input | 3 | Phase value for phase_load |
| cmd_idx | input | 5 | Command buffer entry to show |
| cmd_byte | output | 8 | Selected command buffer entry |
| cmd_pending | output | 1 | Writes are steered to the command buffer |
| cmd_len | output | 6 | Number of captured command bytes |
| fifo_level | output | $clog2(DEPTH)+1 | Bytes held in the data buffer |
| status_reg | output | 8 | Status byte |
| intr_cause | output | 8 | Interrupt cause |
| seq_step | output | 3 | Sequence step |
| fifo_flags | output | 5 | FIFO flags value |
| irq | output | 1 | Interrupt request |

## Verification
The two positions and the level are hidden state, so a fault in them shows up at the ports as a wrong byte order. For example, a read position that fails to return to zero after draining makes the first read after a refill return a stale byte. That can be seen on the very next read. A steering fault is visible on the cycle after the write, through `fifo_level` or `cmd_len`. A lost or duplicated response byte appears in the two reads that follow `resp_load`. The data-out phase rule is probed by draining in that phase and then reading in another, so a skipped byte proves whether the read position was held or moved.

// File: rtl/pio_fifo_pkg.sv
// Shared encodings for the programmed-I/O FIFO port.
// Assumes: byte-wide host access, one decoded operation per cycle.
package pio_fifo_pkg;

    // Decoded host operation, in priority order
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SEL_STOP,
        OP_RESP,
        OP_RELEASE,
        OP_PUSH,
        OP_POP
    } fifo_op_e;

    localparam int          CMD_DEPTH    = 32;
    localparam int          CMD_LW       = $clog2(CMD_DEPTH) + 1;
    localparam int          CMD_IW       = $clog2(CMD_DEPTH);

    localparam logic [2:0]  PH_DATA_OUT  = 3'b000;
    localparam logic [2:0]  PH_COMMAND   = 3'b010;
    localparam logic [2:0]  PH_MSG_IN    = 3'b111;

    localparam logic [7:0]  ST_TERM_CNT  = 8'h10;
    localparam logic [7:0]  IC_FUNC_DONE = 8'h08;
    localparam logic [7:0]  IC_BUS_SVC   = 8'h10;
    localparam logic [2:0]  SEQ_CMD_DONE = 3'd4;
    localparam logic [4:0]  RESP_FLAGS   = 5'd2;

endpackage

// File: rtl/pio_data_buf.sv
// Data byte buffer: circular storage with read/write positions and a level.
// Pushes are dropped at DEPTH-1. A pop in the data-out phase returns zero
// without moving the read position. Both positions reset when the level hits zero.
// Assumes: at most one of flush, load_resp, push, pop per cycle (top decodes).
module pio_data_buf
    import pio_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          load_resp,
    input  logic [7:0]    resp_status,
    input  logic          push,
    input  logic [7:0]    wr_byte,
    input  logic          pop,
    input  logic          zero_read,
    output logic [CW-1:0] level,
    output logic [7:0]    rd_byte
);

    localparam logic [CW-1:0] LVL_MAX  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] LVL_RESP = CW'(2);
    localparam logic [PW-1:0] PTR_RESP = PW'(2);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rptr;
    logic [PW-1:0] wptr;
    logic          push_ok;
    logic          pop_ok;

    // Qualify requests against the level
    always_comb begin
        push_ok = push && (level != LVL_MAX);
        pop_ok  = pop && (level != '0);
    end

    // Storage: host pushes and the two-byte response preload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (load_resp) begin
            mem[0] <= resp_status;
            mem[1] <= 8'h00;
        end else if (push_ok) begin
            mem[wptr] <= wr_byte;
        end
    end

    // Positions, level and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            wptr    <= '0;
            level   <= '0;
            rd_byte <= 8'h00;
        end else if (flush) begin
            rptr  <= '0;
            wptr  <= '0;
            level <= '0;
        end else if (load_resp) begin
            rptr  <= '0;
            wptr  <= PTR_RESP;
            level <= LVL_RESP;
        end else if (push_ok) begin
            wptr  <= wptr + 1'b1;
            level <= level + 1'b1;
        end else if (pop_ok) begin
            level <= level - 1'b1;
            if (zero_read) begin
                rd_byte <= 8'h00;
            end else begin
                rd_byte <= mem[rptr];
                rptr    <= rptr + 1'b1;
            end
            if (level == CW'(1)) begin
                rptr <= '0;
                wptr <= '0;
            end
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_MAX);                                                   // R3
    AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && !load_resp && level == LVL_MAX) |=> $stable(level)); // R3
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && !load_resp && level < LVL_MAX) |=> level == $past(level) + 1'b1); // R2
    AST_DOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && !load_resp && zero_read && level != '0) |=> rd_byte == 8'h00); // R5
    AST_EMPTY_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> (rptr == '0 && wptr == '0));                       // R6

endmodule

// File: rtl/pio_cmd_buf.sv
// Command capture buffer: 32 bytes, filled by host writes while pending.
// Arm clears the length and sets pending; release clears pending only.
// Assumes: arm, release and push are never raised together (top decodes).
module pio_cmd_buf
    import pio_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              release_cmd,
    input  logic              push,
    input  logic [7:0]        wr_byte,
    input  logic [CMD_IW-1:0] rd_idx,
    output logic [7:0]        rd_byte,
    output logic              pending,
    output logic [CMD_LW-1:0] len
);

    localparam logic [CMD_LW-1:0] LEN_FULL = CMD_LW'(CMD_DEPTH);

    logic [7:0] mem [CMD_DEPTH];
    logic       take;

    // A byte is captured only while pending and not full
    always_comb take = push && pending && (len != LEN_FULL);

    // Command byte storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CMD_DEPTH; i++) mem[i] <= 8'h00;
        end else if (take) begin
            mem[len[CMD_IW-1:0]] <= wr_byte;
        end
    end

    // Pending flag and captured length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            len     <= '0;
        end else if (arm) begin
            pending <= 1'b1;
            len     <= '0;
        end else if (release_cmd) begin
            pending <= 1'b0;
        end else if (take) begin
            len <= len + 1'b1;
        end
    end

    // Entry view for the consumer
    always_comb rd_byte = mem[rd_idx];

    AST_CMD_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        len <= LEN_FULL);                                                    // R7
    AST_CMD_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !arm && !release_cmd && len == LEN_FULL) |=> $stable(len)); // R7
    AST_ARM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (pending && len == '0));                                     // R8

endmodule

// File: rtl/pio_ctrl_regs.sv
// Status, interrupt cause, sequence step, FIFO flags and the interrupt line.
// Acknowledge is applied first so that any same-cycle setting event wins.
// Assumes: sel_arm and resp_load are exclusive (top decodes).
module pio_ctrl_regs
    import pio_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_arm,
    input  logic       resp_load,
    input  logic       pop_ok,
    input  logic       irq_ack,
    input  logic       phase_load,
    input  logic [2:0] phase_val,
    output logic [7:0] status_reg,
    output logic [7:0] intr_cause,
    output logic [2:0] seq_step,
    output logic [4:0] fifo_flags,
    output logic       irq
);

    // Register updates in rising order of precedence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_reg <= 8'h00;
            intr_cause <= 8'h00;
            seq_step   <= 3'd0;
            fifo_flags <= 5'd0;
            irq        <= 1'b0;
        end else begin
            if (irq_ack) begin
                irq        <= 1'b0;
                intr_cause <= 8'h00;
            end
            if (phase_load) status_reg[2:0] <= phase_val;
            if (pop_ok) irq <= 1'b1;
            if (sel_arm) begin
                status_reg <= ST_TERM_CNT | {5'b0, PH_COMMAND};
                intr_cause <= IC_BUS_SVC | IC_FUNC_DONE;
                seq_step   <= SEQ_CMD_DONE;
                fifo_flags <= 5'd0;
                irq        <= 1'b1;
            end else if (resp_load) begin
                status_reg[2:0] <= PH_MSG_IN;
                intr_cause      <= IC_FUNC_DONE;
                fifo_flags      <= RESP_FLAGS;
                irq             <= 1'b1;
            end
        end
    end

    AST_READ_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |=> irq);                                                     // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !pop_ok && !sel_arm && !resp_load) |=> (!irq && intr_cause == 8'h00)); // R11
    AST_SEL_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_arm |=> (seq_step == SEQ_CMD_DONE && status_reg == 8'h12 && irq)); // R8
    AST_RESP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_load && !sel_arm) |=> (fifo_flags == RESP_FLAGS && status_reg[2:0] == PH_MSG_IN)); // R10

endmodule

// File: rtl/pio_fifo_port.sv
// Top of the programmed-I/O FIFO port. Decodes one host operation per cycle
// and steers writes to the command buffer while a command is pending.
// Assumes: strobes are single-cycle pulses synchronous to clk.
module pio_fifo_port
    import pio_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [7:0]        host_wr_data,
    input  logic              host_rd,
    output logic [7:0]        host_rd_data,
    input  logic              sel_stop,
    input  logic              resp_load,
    input  logic [7:0]        resp_status,
    input  logic              cmd_release,
    input  logic              irq_ack,
    input  logic              phase_load,
    input  logic [2:0]        phase_val,
    input  logic [CMD_IW-1:0] cmd_idx,
    output logic [7:0]        cmd_byte,
    output logic              cmd_pending,
    output logic [CMD_LW-1:0] cmd_len,
    output logic [CW-1:0]     fifo_level,
    output logic [7:0]        status_reg,
    output logic [7:0]        intr_cause,
    output logic [2:0]        seq_step,
    output logic [4:0]        fifo_flags,
    output logic              irq
);

    fifo_op_e op;
    logic     data_push;
    logic     cmd_push;
    logic     data_pop;
    logic     pop_ok;
    logic     dout_phase;

    // Priority decode of the host strobes
    always_comb begin
        if (sel_stop)         op = OP_SEL_STOP;
        else if (resp_load)   op = OP_RESP;
        else if (cmd_release) op = OP_RELEASE;
        else if (host_wr)     op = OP_PUSH;
        else if (host_rd)     op = OP_POP;
        else                  op = OP_IDLE;
    end

    // Steering of writes and qualification of reads
    always_comb begin
        data_push  = (op == OP_PUSH) && !cmd_pending;
        cmd_push   = (op == OP_PUSH) && cmd_pending;
        data_pop   = (op == OP_POP);
        pop_ok     = data_pop && (fifo_level != '0);
        dout_phase = (status_reg[2:0] == PH_DATA_OUT);
    end

    pio_data_buf #(.DEPTH(DEPTH)) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (op == OP_SEL_STOP),
        .load_resp   (op == OP_RESP),
        .resp_status (resp_status),
        .push        (data_push),
        .wr_byte     (host_wr_data),
        .pop         (data_pop),
        .zero_read   (dout_phase),
        .level       (fifo_level),
        .rd_byte     (host_rd_data)
    );

    pio_cmd_buf u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (op == OP_SEL_STOP),
        .release_cmd (op == OP_RELEASE),
        .push        (cmd_push),
        .wr_byte     (host_wr_data),
        .rd_idx      (cmd_idx),
        .rd_byte     (cmd_byte),
        .pending     (cmd_pending),
        .len         (cmd_len)
    );

    pio_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_arm    (op == OP_SEL_STOP),
        .resp_load  (op == OP_RESP),
        .pop_ok     (pop_ok),
        .irq_ack    (irq_ack),
        .phase_load (phase_load),
        .phase_val  (phase_val),
        .status_reg (status_reg),
        .intr_cause (intr_cause),
        .seq_step   (seq_step),
        .fifo_flags (fifo_flags),
        .irq        (irq)
    );

    AST_PENDING_STEERS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending && host_wr && !sel_stop && !resp_load && !cmd_release) |=> $stable(fifo_level)); // R7
    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_release && !sel_stop && !resp_load) |=> !cmd_pending);          // R9
    AST_RESP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_load && !sel_stop) |=> fifo_level == CW'(2));                  // R10

endmodule

// File: tb/sim_pio_fifo_port.sv
module sim_pio_fifo_port;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [7:0]    host_wr_data = 8'h00;
    logic          host_rd = 1'b0;
    logic [7:0]    host_rd_data;
    logic          sel_stop = 1'b0;
    logic          resp_load = 1'b0;
    logic [7:0]    resp_status = 8'h00;
    logic          cmd_release = 1'b0;
    logic          irq_ack = 1'b0;
    logic          phase_load = 1'b0;
    logic [2:0]    phase_val = 3'd0;
    logic [4:0]    cmd_idx = 5'd0;
    logic [7:0]    cmd_byte;
    logic          cmd_pending;
    logic [5:0]    cmd_len;
    logic [CW-1:0] fifo_level;
    logic [7:0]    status_reg;
    logic [7:0]    intr_cause;
    logic [2:0]    seq_step;
    logic [4:0]    fifo_flags;
    logic          irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pio_fifo_port #(.DEPTH(DEPTH)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Pulse helpers: drive at negedge, release one cycle later
    task automatic do_wr(input logic [7:0] b);
        @(negedge clk); host_wr = 1'b1; host_wr_data = b;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic do_rd();
        @(negedge clk); host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic do_rd_ack();
        @(negedge clk); host_rd = 1'b1; irq_ack = 1'b1;
        @(negedge clk); host_rd = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic do_phase(input logic [2:0] p);
        @(negedge clk); phase_load = 1'b1; phase_val = p;
        @(negedge clk); phase_load = 1'b0;
    endtask

    task automatic do_sel();
        @(negedge clk); sel_stop = 1'b1;
        @(negedge clk); sel_stop = 1'b0;
    endtask

    task automatic do_resp(input logic [7:0] s);
        @(negedge clk); resp_load = 1'b1; resp_status = s;
        @(negedge clk); resp_load = 1'b0;
    endtask

    task automatic do_release();
        @(negedge clk); cmd_release = 1'b1;
        @(negedge clk); cmd_release = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 level", int'(fifo_level), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 status", int'(status_reg), 0);
        chk("R1 intr", int'(intr_cause), 0);
        chk("R1 seq", int'(seq_step), 0);
        chk("R1 flags", int'(fifo_flags), 0);
        chk("R1 pending", int'(cmd_pending), 0);
        chk("R1 cmd_len", int'(cmd_len), 0);
        chk("R1 rd_data", int'(host_rd_data), 0);
    endtask

    task automatic t_order();
        logic [7:0] v [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        do_phase(3'b001);
        chk("R12 phase", int'(status_reg), 8'h01);
        for (int i = 0; i < 5; i++) do_wr(v[i]);
        chk("R2 level", int'(fifo_level), 5);
        for (int i = 0; i < 4; i++) begin
            do_rd();
            chk("R2 order", int'(host_rd_data), int'(v[i]));
        end
        chk("R4 level dec", int'(fifo_level), 1);
        chk("R4 irq set", int'(irq), 1);
        do_ack();
        chk("R11 ack irq", int'(irq), 0);
        do_rd_ack();
        chk("R11 set wins", int'(irq), 1);
        chk("R4 last", int'(host_rd_data), 8'h55);
        do_ack();
        do_rd();
        chk("R4 empty data", int'(host_rd_data), 8'h55);
        chk("R4 empty irq", int'(irq), 0);
        chk("R4 empty level", int'(fifo_level), 0);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 20; i++) do_wr(8'(i + 8'h40));
        chk("R3 level cap", int'(fifo_level), DEPTH - 1);
        for (int i = 0; i < DEPTH - 1; i++) begin
            do_rd();
            chk("R3 kept bytes", int'(host_rd_data), i + 8'h40);
        end
        chk("R3 drained", int'(fifo_level), 0);
    endtask

    task automatic t_dataout();
        do_phase(3'b000);
        do_wr(8'hA1);
        do_wr(8'hB2);
        do_rd();
        chk("R5 zero byte", int'(host_rd_data), 0);
        chk("R5 level", int'(fifo_level), 1);
        do_phase(3'b001);
        do_rd();
        chk("R5 held pos", int'(host_rd_data), 8'hA1);
        do_phase(3'b000);
        do_wr(8'hC3);
        do_wr(8'hD4);
        do_rd();
        do_rd();
        chk("R6 drained", int'(fifo_level), 0);
        do_phase(3'b001);
        do_wr(8'hE5);
        do_rd();
        chk("R6 pos reset", int'(host_rd_data), 8'hE5);
    endtask

    task automatic t_select();
        do_ack();
        do_wr(8'h01);
        do_wr(8'h02);
        do_sel();
        chk("R8 pending", int'(cmd_pending), 1);
        chk("R8 status", int'(status_reg), 8'h12);
        chk("R8 intr", int'(intr_cause), 8'h18);
        chk("R8 seq", int'(seq_step), 4);
        chk("R8 irq", int'(irq), 1);
        chk("R8 flush", int'(fifo_level), 0);
        chk("R8 cmd_len", int'(cmd_len), 0);
        do_wr(8'h12);
        do_wr(8'h34);
        do_wr(8'h56);
        chk("R7 cmd_len", int'(cmd_len), 3);
        chk("R7 level kept", int'(fifo_level), 0);
        @(negedge clk); cmd_idx = 5'd1; #1;
        chk("R7 cmd_byte", int'(cmd_byte), 8'h34);
        for (int k = 0; k < 40; k++) do_wr(8'(k));
        chk("R7 cmd full", int'(cmd_len), 32);
        @(negedge clk); cmd_idx = 5'd31; #1;
        chk("R7 last entry", int'(cmd_byte), 28);
        do_release();
        chk("R9 released", int'(cmd_pending), 0);
        do_wr(8'h77);
        chk("R9 to data", int'(fifo_level), 1);
        chk("R9 len kept", int'(cmd_len), 32);
        do_rd();
        chk("R9 read back", int'(host_rd_data), 8'h77);
    endtask

    task automatic t_resp();
        do_phase(3'b000);
        chk("R12 upper kept", int'(status_reg), 8'h10);
        do_ack();
        do_resp(8'h02);
        chk("R10 level", int'(fifo_level), 2);
        chk("R10 flags", int'(fifo_flags), 2);
        chk("R10 intr", int'(intr_cause), 8'h08);
        chk("R10 status", int'(status_reg), 8'h17);
        chk("R10 irq", int'(irq), 1);
        do_rd();
        chk("R10 status byte", int'(host_rd_data), 8'h02);
        do_rd();
        chk("R10 msg byte", int'(host_rd_data), 8'h00);
        chk("R10 empty", int'(fifo_level), 0);
        do_phase(3'b011);
        chk("R12 phase load", int'(status_reg), 8'h13);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_overrun();
        t_dataout();
        t_select();
        t_resp();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule